// File: doc/BRIEF.md
# Slot-Table Thread Interleave Scheduler

This block decides, on every cycle, which hardware thread may place an instruction into a shared single-issue pipeline. It has three scheduling modes.

- **Fixed mode:** a strict rotation over all threads.
- **Table mode:** a software-written slot table that the hardware walks in a fixed rotation.
- **Ready mode:** the block picks one of the currently ready threads with rotating priority.

In fixed mode and table mode, a slot whose owner is not ready is left empty and becomes a bubble. The slot is never handed to another thread.

The chosen thread index travels with the issue through a delay line of one register per pipeline stage, with a valid bit per stage. Each later stage can therefore tell whose state to read or write, and can tell when it holds a bubble. Table writes go to a shadow copy. That copy becomes active only when the slot pointer wraps.

Top module: `thread_issue_sched`

## Requirements
- R1: After reset every delay-line stage is invalid, the rotation counter and the slot pointer are zero, table entry i holds i mod N_THREADS, and the ready-mode search starts at thread 0.
- R2: In fixed mode (mode_i 0), the slot owner is thread (k mod N_THREADS) on the k-th clock after reset. The rotation counter advances every cycle in every mode. The owner issues when its ready bit is set.
- R3: In fixed mode and table mode, when the slot owner is not ready, issue_valid_o is 0 and bubble_o is 1, whatever other threads are ready.
- R4: In table mode (mode_i 1), the slot pointer is (k mod N_SLOTS) on the k-th clock after reset and advances every cycle in every mode. The thread named by the active entry at the pointer issues when it is ready.
- R5: A table entry whose value is N_THREADS or greater is empty and always yields a bubble.
- R6: A write (tbl_we_i, tbl_addr_i, tbl_wdata_i) lands in the shadow table. The whole shadow is copied to the active table on the clock where the pointer moves from N_SLOTS-1 to 0. A write made on that same clock waits for the following wrap.
- R7: In ready mode (mode_i 2), the issuing thread is the first ready thread found when searching upward, modulo N_THREADS, from the thread after the last one issued in ready mode.
- R8: In ready mode, a bubble occurs only when no thread is ready.
- R9: Stage j of the delay line (pipe_valid_o bit j, pipe_tid_o field j) holds the issue valid and thread index from j+1 cycles earlier.
- R10: mode_i 3 behaves exactly like fixed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 fixed, 1 table, 2 ready, 3 fixed |
| ready_i | input | N_THREADS | Per-thread ready bits |
| tbl_we_i | input | 1 | Slot table write enable |
| tbl_addr_i | input | SLOT_W | Slot index to write |
| tbl_wdata_i | input | ENT_W | Thread index for the slot; N_THREADS or more means empty |
| issue_valid_o | output | 1 | A thread issues this cycle |
| issue_tid_o | output | TID_W | Issuing thread index |
| bubble_o | output | 1 | This cycle is a bubble |
| pipe_valid_o | output | PIPE_DEPTH | Valid bit per delay-line stage |
| pipe_tid_o | output | PIPE_DEPTH*TID_W | Thread index per stage, stage 0 in the low bits |

## Verification
A stuck or skipped rotation counter gives the wrong owner in fixed mode within one cycle, as soon as the owner's ready bit differs from the expected owner's. A slot pointer that is off by one, or a commit made at the wrong time, shows up as a wrong thread in table mode no later than the first wrap after a write. A stale last-issued register in ready mode shows as a wrong grant the first time two or more threads are ready together. A delay-line fault appears j+1 cycles after the issue at stage j. For these reasons the bench compares every output on every cycle, under random ready patterns and random table writes.

// File: rtl/isched_pkg.sv
package isched_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED   = 2'd0,
    MODE_TABLE   = 2'd1,
    MODE_READY   = 2'd2,
    MODE_FIXED_B = 2'd3
  } sched_mode_e;
endpackage

// File: rtl/isched_slot_table.sv
module isched_slot_table #(
  parameter int N_THREADS = 4,
  parameter int N_SLOTS   = 8,
  parameter int ENT_W     = 3,
  parameter int SLOT_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] waddr_i,
  input  logic [ENT_W-1:0]  wdata_i,
  input  logic              commit_i,
  input  logic [SLOT_W-1:0] raddr_i,
  output logic [ENT_W-1:0]  rdata_o
);
  logic [ENT_W-1:0] shd_q [N_SLOTS];
  logic [ENT_W-1:0] act_q [N_SLOTS];

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    localparam logic [ENT_W-1:0] RstVal = ENT_W'(s % N_THREADS);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shd_q[s] <= RstVal;
        act_q[s] <= RstVal;
      end else begin
        // commit takes the pre-write shadow value
        if (commit_i) act_q[s] <= shd_q[s];
        if (we_i && waddr_i == SLOT_W'(s)) shd_q[s] <= wdata_i;
      end
    end
  end

  assign rdata_o = act_q[raddr_i];
endmodule

// File: rtl/isched_rr_arbiter.sv
module isched_rr_arbiter #(
  parameter int N_THREADS = 4,
  parameter int TID_W     = 2
) (
  input  logic [N_THREADS-1:0] req_i,
  input  logic [TID_W-1:0]     last_i,
  output logic                 gnt_valid_o,
  output logic [TID_W-1:0]     gnt_idx_o
);
  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int i = 1; i <= N_THREADS; i++) begin
      int cand;
      cand = (int'(last_i) + i) % N_THREADS;
      if (!gnt_valid_o && req_i[cand]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = TID_W'(cand);
      end
    end
  end
endmodule

// File: rtl/isched_tid_pipe.sv
module isched_tid_pipe #(
  parameter int DEPTH = 5,
  parameter int TID_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [TID_W-1:0]       tid_i,
  output logic [DEPTH-1:0]       valid_o,
  output logic [DEPTH*TID_W-1:0] tid_o
);
  logic [DEPTH-1:0] v_q;
  logic [TID_W-1:0] t_q [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_stage
    logic             v_in;
    logic [TID_W-1:0] t_in;
    if (j == 0) begin : g_head
      assign v_in = valid_i;
      assign t_in = tid_i;
    end else begin : g_body
      assign v_in = v_q[j-1];
      assign t_in = t_q[j-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[j] <= 1'b0;
        t_q[j] <= '0;
      end else begin
        v_q[j] <= v_in;
        t_q[j] <= t_in;
      end
    end
    assign tid_o[j*TID_W +: TID_W] = t_q[j];
  end

  assign valid_o = v_q;
endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched
  import isched_pkg::*;
#(
  parameter int N_THREADS  = 4,
  parameter int N_SLOTS    = 8,
  parameter int PIPE_DEPTH = 5,
  localparam int TID_W     = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
  localparam int ENT_W     = $clog2(N_THREADS) + 1,
  localparam int SLOT_W    = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [1:0]                  mode_i,
  input  logic [N_THREADS-1:0]        ready_i,
  input  logic                        tbl_we_i,
  input  logic [SLOT_W-1:0]           tbl_addr_i,
  input  logic [ENT_W-1:0]            tbl_wdata_i,
  output logic                        issue_valid_o,
  output logic [TID_W-1:0]            issue_tid_o,
  output logic                        bubble_o,
  output logic [PIPE_DEPTH-1:0]       pipe_valid_o,
  output logic [PIPE_DEPTH*TID_W-1:0] pipe_tid_o
);
  localparam logic [TID_W-1:0]  LastTid = TID_W'(N_THREADS - 1);
  localparam logic [SLOT_W-1:0] LastSlot = SLOT_W'(N_SLOTS - 1);

  sched_mode_e      mode;
  logic [TID_W-1:0] rr_q, last_q;
  logic [SLOT_W-1:0] ptr_q;
  logic             wrap;
  logic [ENT_W-1:0] slot_ent;
  logic             arb_v;
  logic [TID_W-1:0] arb_idx;
  logic             sel_v;
  logic [TID_W-1:0] sel_tid;

  assign mode = sched_mode_e'(mode_i);
  assign wrap = (ptr_q == LastSlot);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q   <= '0;
      ptr_q  <= '0;
      last_q <= LastTid;
    end else begin
      rr_q  <= (rr_q == LastTid) ? '0 : rr_q + 1'b1;
      ptr_q <= wrap ? '0 : ptr_q + 1'b1;
      if (mode == MODE_READY && sel_v) last_q <= sel_tid;
    end
  end

  isched_slot_table #(
    .N_THREADS(N_THREADS), .N_SLOTS(N_SLOTS), .ENT_W(ENT_W), .SLOT_W(SLOT_W)
  ) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_wdata_i),
    .commit_i(wrap),
    .raddr_i (ptr_q),
    .rdata_o (slot_ent)
  );

  isched_rr_arbiter #(.N_THREADS(N_THREADS), .TID_W(TID_W)) u_arb (
    .req_i      (ready_i),
    .last_i     (last_q),
    .gnt_valid_o(arb_v),
    .gnt_idx_o  (arb_idx)
  );

  always_comb begin
    sel_v   = 1'b0;
    sel_tid = '0;
    unique case (mode)
      MODE_TABLE: begin
        // out-of-range entry means empty slot
        if (int'(slot_ent) < N_THREADS) begin
          sel_tid = slot_ent[TID_W-1:0];
          sel_v   = ready_i[sel_tid];
        end
      end
      MODE_READY: begin
        sel_v   = arb_v;
        sel_tid = arb_idx;
      end
      default: begin
        sel_tid = rr_q;
        sel_v   = ready_i[rr_q];
      end
    endcase
  end

  assign issue_valid_o = sel_v;
  assign issue_tid_o   = sel_tid;
  assign bubble_o      = ~sel_v;

  isched_tid_pipe #(.DEPTH(PIPE_DEPTH), .TID_W(TID_W)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(sel_v),
    .tid_i  (sel_tid),
    .valid_o(pipe_valid_o),
    .tid_o  (pipe_tid_o)
  );
endmodule

// File: rtl/thread_issue_sched_chk.sv
module thread_issue_sched_chk #(
  parameter int N_THREADS  = 4,
  parameter int PIPE_DEPTH = 5,
  parameter int TID_W      = 2
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [1:0]                  mode_i,
  input logic [N_THREADS-1:0]        ready_i,
  input logic                        issue_valid_o,
  input logic [TID_W-1:0]            issue_tid_o,
  input logic                        bubble_o,
  input logic [PIPE_DEPTH-1:0]       pipe_valid_o,
  input logic [PIPE_DEPTH*TID_W-1:0] pipe_tid_o
);
  logic             started_q, prev_v_q;
  logic [TID_W-1:0] prev_tid_q;
  logic [1:0]       prev_mode_q;
  logic [TID_W-1:0] next_tid;
  logic             fixed_now, fixed_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q   <= 1'b0;
      prev_v_q    <= 1'b0;
      prev_tid_q  <= '0;
      prev_mode_q <= '0;
    end else begin
      started_q   <= 1'b1;
      prev_v_q    <= issue_valid_o;
      prev_tid_q  <= issue_tid_o;
      prev_mode_q <= mode_i;
    end
  end

  assign next_tid   = (int'(prev_tid_q) == N_THREADS - 1) ? '0 : prev_tid_q + 1'b1;
  assign fixed_now  = (mode_i == 2'd0) || (mode_i == 2'd3);
  assign fixed_prev = (prev_mode_q == 2'd0) || (prev_mode_q == 2'd3);

  p_bubble_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bubble_o != issue_valid_o);

  p_fixed_owner_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fixed_now && issue_valid_o) |-> ready_i[issue_tid_o]);

  p_fixed_rotation_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && fixed_now && fixed_prev && issue_valid_o && prev_v_q)
      |-> issue_tid_o == next_tid);

  p_ready_grant_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && issue_valid_o) |-> ready_i[issue_tid_o]);

  p_ready_next_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && mode_i == 2'd2 && prev_mode_q == 2'd2 && prev_v_q && ready_i[next_tid])
      |-> (issue_valid_o && issue_tid_o == next_tid));

  p_ready_no_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && |ready_i) |-> issue_valid_o);

  p_pipe_head_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> (pipe_valid_o[0] == prev_v_q &&
                   (!prev_v_q || pipe_tid_o[TID_W-1:0] == prev_tid_q)));

  p_pipe_shift_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> pipe_valid_o[PIPE_DEPTH-1:1] == $past(pipe_valid_o[PIPE_DEPTH-2:0]));
endmodule

bind thread_issue_sched thread_issue_sched_chk #(
  .N_THREADS(N_THREADS), .PIPE_DEPTH(PIPE_DEPTH), .TID_W(TID_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .ready_i      (ready_i),
  .issue_valid_o(issue_valid_o),
  .issue_tid_o  (issue_tid_o),
  .bubble_o     (bubble_o),
  .pipe_valid_o (pipe_valid_o),
  .pipe_tid_o   (pipe_tid_o)
);

// File: tb/thread_issue_sched_tb_top.sv
module thread_issue_sched_tb_top;
  localparam int N  = 4;
  localparam int S  = 8;
  localparam int D  = 5;
  localparam int TW = 2;
  localparam int EW = 3;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = '0;
  logic [N-1:0]  ready = '0;
  logic          we = 1'b0;
  logic [SW-1:0] waddr = '0;
  logic [EW-1:0] wdata = '0;
  logic          iv, bub;
  logic [TW-1:0] itid;
  logic [D-1:0]  pv;
  logic [D*TW-1:0] pt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int m_rr, m_ptr, m_last;
  int m_act[S];
  int m_shd[S];
  int m_pv[D];
  int m_pt[D];

  always #5 clk = ~clk;

  thread_issue_sched #(.N_THREADS(N), .N_SLOTS(S), .PIPE_DEPTH(D)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ready_i(ready),
    .tbl_we_i(we), .tbl_addr_i(waddr), .tbl_wdata_i(wdata),
    .issue_valid_o(iv), .issue_tid_o(itid), .bubble_o(bub),
    .pipe_valid_o(pv), .pipe_tid_o(pt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    m_rr = 0; m_ptr = 0; m_last = N - 1;
    for (int i = 0; i < S; i++) begin m_act[i] = i % N; m_shd[i] = i % N; end
    for (int j = 0; j < D; j++) begin m_pv[j] = 0; m_pt[j] = 0; end
  endfunction

  // expected combinational decision from model state
  function automatic void model_pick(output int v, output int t, output string req);
    v = 0; t = 0;
    case (int'(mode))
      1: begin
        if (m_act[m_ptr] >= N) req = "R5";
        else begin
          t = m_act[m_ptr]; v = ready[t];
          req = v ? "R4/R6" : "R3";
        end
      end
      2: begin
        req = "R7";
        for (int i = 1; i <= N; i++) begin
          int c;
          c = (m_last + i) % N;
          if (v == 0 && ready[c]) begin v = 1; t = c; end
        end
        if (v == 0) req = "R8";
      end
      default: begin
        t = m_rr; v = ready[t];
        req = (mode == 2'd3) ? "R10" : (v ? "R2" : "R3");
      end
    endcase
  endfunction

  task automatic step();
    int v, t;
    string req;
    @(negedge clk);
    model_pick(v, t, req);
    chk(iv == v[0], req, int'(iv), v);
    chk(bub == !v[0], req, int'(bub), int'(!v[0]));
    if (v != 0) chk(int'(itid) == t, req, int'(itid), t);
    for (int j = 0; j < D; j++) begin
      chk(pv[j] == m_pv[j][0], "R9", int'(pv[j]), m_pv[j]);
      if (m_pv[j] != 0)
        chk(int'(pt[j*TW +: TW]) == m_pt[j], "R9", int'(pt[j*TW +: TW]), m_pt[j]);
    end
    for (int j = D - 1; j > 0; j--) begin m_pv[j] = m_pv[j-1]; m_pt[j] = m_pt[j-1]; end
    m_pv[0] = v; m_pt[0] = t;
    m_rr = (m_rr + 1) % N;
    if (m_ptr == S - 1) for (int i = 0; i < S; i++) m_act[i] = m_shd[i];
    if (we) m_shd[waddr] = int'(wdata);
    m_ptr = (m_ptr + 1) % S;
    if (mode == 2'd2 && v != 0) m_last = t;
    @(posedge clk);
    #1;
  endtask

  task automatic run(input int cycles, input int md, input int wprob);
    for (int c = 0; c < cycles; c++) begin
      mode  = 2'(md);
      ready = N'($urandom);
      we    = ($urandom % 100) < wprob;
      waddr = SW'($urandom);
      wdata = EW'($urandom % 6);
      step();
    end
    we = 1'b0;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    model_reset();
    #22;
    // R1: reset state at the ports
    ready = '1;
    #1;
    chk(pv == '0, "R1", int'(pv), 0);
    chk(iv && itid == '0, "R1", int'(itid), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    model_reset(); m_rr = 1; m_ptr = 1;
    m_pv[0] = 1; m_pt[0] = 0;
    // R2: all ready, full rotation
    ready = '1; mode = 2'd0;
    repeat (2 * N) step();
    // R3: only thread 2 ready, others own bubbles
    ready = N'(4);
    repeat (2 * N) step();
    // R4: all ready, walk reset table
    mode = 2'd1; ready = '1;
    repeat (S) step();
    // R5/R6: write empty entry mid-rotation, observe only after wrap
    while (m_ptr != 2) step();
    we = 1'b1; waddr = 3'd5; wdata = 3'd4;
    step();
    we = 1'b0;
    repeat (2 * S) step();
    // R7: two threads ready, rotation between them
    mode = 2'd2; ready = N'(4'b1010);
    repeat (6) step();
    // R8: nothing ready
    ready = '0;
    repeat (3) step();
    run(400, 0, 0);
    run(600, 1, 20);
    run(400, 2, 10);
    run(200, 3, 10);
    for (int k = 0; k < 1500; k++) run(1, int'($urandom % 4), 15);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule